// File: doc/BRIEF.md
# Programmable Digital Glitch Filter

This block is a bank of per-pin digital glitch filters that share one width setting and one filter-clock select. Each filter copies an input level to its output only after the input has held a level different from the output for more filter ticks than the programmed width. Any shorter excursion is absorbed and the output does not move. A filter that is switched off drives zero.

The filter tick is either every bus-clock cycle or a single-cycle enable pulse on `slow_tick`, which stands in for a slow low-power clock. The whole block runs on one clock. A simple register port holds three settings: the per-pin enable mask, the tick select and the width. The tick select and the width can only be changed while every filter is off. The pins reach the block already synchronous to `clk`.

Each pin has a small state machine with three states. `FLT_OFF` drives zero and holds the counter clear. `FLT_STABLE` means the input matches the output. `FLT_QUALIFY` means the input differs from the output and the counter is running. The transitions are:
- `FLT_OFF` → `FLT_STABLE` when the pin's enable bit is set.
- Any state → `FLT_OFF` when the enable bit is clear.
- `FLT_STABLE` → `FLT_QUALIFY` on a tick that sees a mismatch while the width is non-zero. With a width of zero, the same tick updates the output and the filter stays in `FLT_STABLE`.
- `FLT_QUALIFY` → `FLT_STABLE` when the input returns to the output level (glitch absorbed), or on the tick that takes the count past the width (output updated).

Top module: `pin_glitch_filter`

## Requirements
- R1: After reset, every `pin_out` bit is 0 and the enable, select and width registers all read 0.
- R2: A pin whose enable bit is clear drives 0. Clearing the bit forces the output to 0 one cycle after the write edge, whatever the input does.
- R3: A level that differs from the output for at most `width` consecutive filter ticks leaves the output unchanged.
- R4: A level that differs from the output for `width`+1 consecutive filter ticks is copied to the output at the edge of that (`width`+1)-th tick. With the bus clock selected, this is the (`width`+1)-th clock edge after the input changes.
- R5: With a width of 0, an enabled output follows its input at the first tick that sees the change.
- R6: When the select bit reads 1, the counters advance only on cycles where `slow_tick` is 1. With no `slow_tick` pulse, the output does not change.
- R7: A write to the select or width register is ignored while any enable bit is set, and the old value reads back.
- R8: Enable bit i controls only pin i. A disabled pin stays at 0 while its neighbours filter normally.
- R9: The register map is as follows. Offset 0x00 holds the enable mask, with bit i for pin i. Offset 0x04 holds the select in bit 0 (0 = every clock, 1 = `slow_tick`). Offset 0x08 holds the width in bits 4:0, and a write keeps only those bits. Any other offset reads 0.
- R10: Falling changes are filtered exactly like rising ones: a low glitch of at most `width` ticks on a high output is absorbed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state is on this clock |
| rst_n | input | 1 | Active-low reset |
| slow_tick | input | 1 | Single-cycle slow-clock enable pulse |
| reg_wr | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | ADDR_W (8) | Register byte offset |
| reg_wdata | input | DATA_W (32) | Register write data |
| reg_rdata | output | DATA_W (32) | Read data for `reg_addr` (combinational) |
| pin_in | input | NPINS (32) | Synchronous pin inputs |
| pin_out | output | NPINS (32) | Filtered pin outputs |

## Verification
The properties assume three things: `pin_in` is already synchronous to `clk`, `slow_tick` is a clean single-cycle pulse in the same domain, and `rst_n` is held low for at least one edge. The check that output moves only on a tick and only toward the sampled input relies on those assumptions. The bench drives every input one time unit after a rising edge and samples there as well. It changes the width and select only after clearing the enable mask, except in the R7 case, which deliberately tries a write while a filter is enabled.

// File: rtl/pgf_pkg.sv
`timescale 1ns/1ps
package pgf_pkg;
    // Register offsets (byte addresses on the register port)
    localparam int unsigned OFS_ENABLE = 'h00;
    localparam int unsigned OFS_SELECT = 'h04;
    localparam int unsigned OFS_WIDTH  = 'h08;

    typedef enum logic [1:0] {
        FLT_OFF     = 2'd0,
        FLT_STABLE  = 2'd1,
        FLT_QUALIFY = 2'd2
    } flt_state_e;
endpackage

// File: rtl/pgf_regs.sv
`timescale 1ns/1ps
module pgf_regs
    import pgf_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NPINS-1:0]  en_mask,
    output logic              clk_sel,
    output logic [CNT_W-1:0]  width_val
);
    logic hit_en, hit_sel, hit_width, cfg_open;
    logic wdata_unused;

    assign hit_en    = (reg_addr == ADDR_W'(OFS_ENABLE));
    assign hit_sel   = (reg_addr == ADDR_W'(OFS_SELECT));
    assign hit_width = (reg_addr == ADDR_W'(OFS_WIDTH));
    // R7: shared settings are writable only with every filter off
    assign cfg_open  = (en_mask == '0);
    assign wdata_unused = ^reg_wdata;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_mask   <= '0;
            clk_sel   <= 1'b0;
            width_val <= '0;
        end else if (reg_wr) begin
            if (hit_en)
                en_mask <= reg_wdata[NPINS-1:0];
            if (hit_sel && cfg_open)
                clk_sel <= reg_wdata[0];
            if (hit_width && cfg_open)
                width_val <= reg_wdata[CNT_W-1:0];
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (hit_en)
            reg_rdata = DATA_W'(en_mask);
        else if (hit_sel)
            reg_rdata = DATA_W'(clk_sel);
        else if (hit_width)
            reg_rdata = DATA_W'(width_val);
    end
endmodule

// File: rtl/pgf_tick_sel.sv
`timescale 1ns/1ps
module pgf_tick_sel (
    input  logic clk_sel,
    input  logic slow_tick,
    output logic filt_tick
);
    // 0: every bus-clock cycle is a tick; 1: only slow_tick cycles
    assign filt_tick = clk_sel ? slow_tick : 1'b1;
endmodule

// File: rtl/pgf_cell.sv
`timescale 1ns/1ps
module pgf_cell
    import pgf_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             din,
    input  logic [CNT_W-1:0] width,
    output logic             dout
);
    flt_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d;
    logic [CNT_W:0]   cnt_inc;
    logic             qualified;

    assign cnt_inc   = {1'b0, cnt_q} + 1'b1;
    assign qualified = (cnt_inc > {1'b0, width});

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLT_OFF;
        else        state_q <= state_d;
    end

    // Counter and output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            out_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            out_q <= out_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        out_d   = out_q;
        unique case (state_q)
            FLT_OFF: begin
                out_d = 1'b0;
                cnt_d = '0;
                if (enable) state_d = FLT_STABLE;
            end
            FLT_STABLE: begin
                cnt_d = '0;
                if (!enable) begin
                    state_d = FLT_OFF;
                    out_d   = 1'b0;
                end else if (tick && (din != out_q)) begin
                    if (qualified) out_d = din;
                    else begin
                        cnt_d   = cnt_inc[CNT_W-1:0];
                        state_d = FLT_QUALIFY;
                    end
                end
            end
            FLT_QUALIFY: begin
                if (!enable) begin
                    state_d = FLT_OFF;
                    out_d   = 1'b0;
                    cnt_d   = '0;
                end else if (din == out_q) begin
                    state_d = FLT_STABLE;
                    cnt_d   = '0;
                end else if (tick) begin
                    if (qualified) begin
                        out_d   = din;
                        cnt_d   = '0;
                        state_d = FLT_STABLE;
                    end else begin
                        cnt_d = cnt_inc[CNT_W-1:0];
                    end
                end
            end
            default: begin
                state_d = FLT_OFF;
                out_d   = 1'b0;
                cnt_d   = '0;
            end
        endcase
    end

    assign dout = out_q;
endmodule

// File: rtl/pin_glitch_filter.sv
`timescale 1ns/1ps
module pin_glitch_filter #(
    parameter int NPINS  = 32,
    parameter int CNT_W  = 5,
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slow_tick,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out
);
    logic [NPINS-1:0] en_mask;
    logic             clk_sel;
    logic [CNT_W-1:0] width_val;
    logic             filt_tick;

    pgf_regs #(
        .NPINS(NPINS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .en_mask(en_mask),
        .clk_sel(clk_sel), .width_val(width_val)
    );

    pgf_tick_sel u_tick (
        .clk_sel(clk_sel), .slow_tick(slow_tick), .filt_tick(filt_tick)
    );

    for (genvar i = 0; i < NPINS; i++) begin : g_cell
        pgf_cell #(.CNT_W(CNT_W)) u_cell (
            .clk(clk), .rst_n(rst_n), .enable(en_mask[i]), .tick(filt_tick),
            .din(pin_in[i]), .width(width_val), .dout(pin_out[i])
        );
    end
endmodule

// File: rtl/pgf_checker.sv
`timescale 1ns/1ps
module pgf_checker #(
    parameter int NPINS = 32,
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic [NPINS-1:0] pin_in,
    input logic [NPINS-1:0] pin_out,
    input logic [NPINS-1:0] en_mask,
    input logic             clk_sel,
    input logic [CNT_W-1:0] width_val,
    input logic             filt_tick
);
    // R2: a pin disabled in the previous cycle drives zero now
    a_r2_disabled_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_out & ~$past(en_mask)) == '0);

    // R7: settings hold while any filter is enabled
    a_r7_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (|en_mask) |=> ($stable(width_val) && $stable(clk_sel)));

    // R6: an enabled output moves only after a tick cycle
    a_r6_move_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(filt_tick) |-> (((pin_out ^ $past(pin_out)) & $past(en_mask)) == '0));

    // R4: an enabled output only ever moves to the level just sampled
    a_r4_move_to_input: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_out ^ $past(pin_out)) & $past(en_mask) & (pin_out ^ $past(pin_in))) == '0);
endmodule

bind pin_glitch_filter pgf_checker #(.NPINS(NPINS), .CNT_W(CNT_W)) u_pgf_chk (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out),
    .en_mask(en_mask), .clk_sel(clk_sel), .width_val(width_val),
    .filt_tick(filt_tick)
);

// File: tb/pin_glitch_filter_test.sv
`timescale 1ns/1ps
module pin_glitch_filter_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        slow_tick = 1'b0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    localparam logic [7:0] A_EN = 8'h00, A_SEL = 8'h04, A_WID = 8'h08;

    always #2 clk = ~clk;  // 250 MHz

    pin_glitch_filter uut (
        .clk(clk), .rst_n(rst_n), .slow_tick(slow_tick), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_out(pin_out)
    );

    task automatic cyc();
        @(posedge clk); #1;
    endtask

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        cyc();
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        reg_addr = a; #1;
        chk(reg_rdata, exp, tag);
    endtask

    task automatic t_reset();
        chk(pin_out, 32'h0, "R1 outputs after reset");
        rd(A_EN, 0, "R1 enable after reset");
        rd(A_SEL, 0, "R1 select after reset");
        rd(A_WID, 0, "R1 width after reset");
    endtask

    task automatic t_regmap();
        wr(A_WID, 32'h3F);
        rd(A_WID, 32'h1F, "R9 width keeps bits 4:0");
        rd(8'h0C, 0, "R9 unmapped offset reads 0");
        wr(A_WID, 3);
        rd(A_WID, 3, "R9 width readback");
        wr(A_EN, 1);
        rd(A_EN, 1, "R9 enable readback");
        cyc(); cyc();
    endtask

    task automatic t_reject_pass();
        // R3: a 3-tick high glitch with width 3 is absorbed
        pin_in[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc(); chk(pin_out[0], 0, "R3 glitch during");
        end
        pin_in[0] = 1'b0;
        for (int i = 0; i < 4; i++) cyc();
        chk(pin_out[0], 0, "R3 glitch absorbed");
        // R4: a 4-tick level passes on the 4th edge
        pin_in[0] = 1'b1;
        for (int i = 0; i < 3; i++) begin
            cyc(); chk(pin_out[0], 0, "R4 before width+1");
        end
        cyc(); chk(pin_out[0], 1, "R4 rises at width+1");
        // R10: a low glitch of 3 ticks is absorbed, a 4-tick low passes
        pin_in[0] = 1'b0;
        for (int i = 0; i < 3; i++) begin
            cyc(); chk(pin_out[0], 1, "R10 low glitch during");
        end
        pin_in[0] = 1'b1;
        cyc(); chk(pin_out[0], 1, "R10 low glitch absorbed");
        pin_in[0] = 1'b0;
        for (int i = 0; i < 3; i++) cyc();
        chk(pin_out[0], 1, "R10 before fall");
        cyc(); chk(pin_out[0], 0, "R10 falls at width+1");
        pin_in[0] = 1'b1;
        for (int i = 0; i < 4; i++) cyc();
        chk(pin_out[0], 1, "R4 high again");
    endtask

    task automatic t_frozen();
        wr(A_WID, 7);
        rd(A_WID, 3, "R7 width write ignored while enabled");
        wr(A_SEL, 1);
        rd(A_SEL, 0, "R7 select write ignored while enabled");
    endtask

    task automatic t_indep();
        pin_in[1] = 1'b1;
        for (int i = 0; i < 10; i++) cyc();
        chk(pin_out[1], 0, "R8 disabled neighbour stays 0");
        chk(pin_out[0], 1, "R8 enabled pin unaffected");
    endtask

    task automatic t_disable();
        wr(A_EN, 0);
        chk(pin_out[0], 1, "R2 output before disable takes effect");
        cyc();
        chk(pin_out, 0, "R2 forced to 0 after disable");
        for (int i = 0; i < 5; i++) cyc();
        chk(pin_out, 0, "R2 stays 0 with input high");
    endtask

    task automatic t_width0();
        wr(A_WID, 0);
        rd(A_WID, 0, "R5 width 0 accepted while disabled");
        wr(A_EN, 32'h4);
        cyc();
        pin_in[2] = 1'b1;
        cyc(); chk(pin_out[2], 1, "R5 follows after one tick");
        pin_in[2] = 1'b0;
        cyc(); chk(pin_out[2], 0, "R5 falls after one tick");
    endtask

    task automatic t_slow();
        wr(A_EN, 0);
        cyc();
        wr(A_WID, 1);
        wr(A_SEL, 1);
        rd(A_SEL, 1, "R6 select accepted while disabled");
        wr(A_EN, 32'h8);
        cyc();
        pin_in[3] = 1'b1;
        for (int i = 0; i < 10; i++) cyc();
        chk(pin_out[3], 0, "R6 no tick, no change");
        slow_tick = 1'b1; cyc(); slow_tick = 1'b0;
        chk(pin_out[3], 0, "R6 first tick counted only");
        for (int i = 0; i < 3; i++) cyc();
        chk(pin_out[3], 0, "R6 waiting for second tick");
        slow_tick = 1'b1; cyc(); slow_tick = 1'b0;
        chk(pin_out[3], 1, "R6 passes on second tick");
    endtask

    initial begin
        for (int i = 0; i < 3; i++) cyc();
        rst_n = 1'b1;
        cyc();
        t_reset();
        t_regmap();
        t_reject_pass();
        t_frozen();
        t_indep();
        t_disable();
        t_width0();
        t_slow();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule